// File: doc/BRIEF.md
# Multi-Mode Line Loss-of-Signal Monitor

This block watches the bit stream recovered from a line receiver and decides when the line has gone dead and when it has come back. It takes one sample per clock. Each sample has a mark bit, which says a pulse was seen in that interval, and a level-valid bit, which says the analog front end measured an adequate amplitude. The monitor raises a loss-of-signal flag after a mode-specific run of empty intervals. It lowers the flag again only when a mode-specific recovery test passes.

Three criteria are available. The short E1 criterion recovers on ones density inside a sliding window, with a limit on the longest zero run in that window. The T1 criterion recovers on mark density over a fixed window that opens on a mark. The extended E1 criterion recovers on a run of intervals with valid level.

Alongside the flag, the block drives a clock-select output that tells a downstream clock multiplexer to use the master clock while the line is lost. The received data is passed through untouched in every state.

Top module: `los_monitor`

## Requirements
- R1: A zero-run count grows by one on every interval without a mark and returns to zero on every interval with a mark. LOS never rises at the end of an interval that carried a mark, unless that interval restarts detection under R12.
- R2: In E1 mode (ext_mode_i=0, line_t1_i=0), LOS rises after E1_SET (default 32) consecutive intervals without a mark. los_o is high from the clock after the last of them is sampled.
- R3: In E1 mode, LOS falls at the end of an interval when three conditions all hold. The newest E1_WIN (32) samples, counting the current one and treating samples taken before the last restart as zeros, hold at least E1_MIN_MARKS (4) marks. No run of more than E1_MAX_ZRUN (15) zeros lies inside those samples. lvl_ok_i is high in that interval.
- R4: In T1 mode (ext_mode_i=0, line_t1_i=1), LOS rises after T1_SET (175) consecutive intervals without a mark.
- R5: In T1 mode, while LOS is high, a window of T1_WIN (175) intervals opens on a mark interval, and that interval counts as the window's first. When the window completes with at least T1_MIN_MARKS (22) marks, LOS falls at the end of its last interval. Otherwise the window closes, and the next one opens on the next mark after it.
- R6: In extended mode (ext_mode_i=1), LOS rises after EXT_SET (2048) consecutive intervals without a mark.
- R7: In extended mode, LOS falls at the end of the EXT_CLR-th (33rd) consecutive interval with lvl_ok_i high. Any interval with lvl_ok_i low restarts that count.
- R8: ext_mode_i=1 selects extended mode whatever line_t1_i is. Otherwise line_t1_i=1 selects T1 mode and line_t1_i=0 selects E1 mode.
- R9: use_mclk_o (1 = master clock) equals the value los_o had one clock earlier, so the clock path switches on the clock after any LOS change.
- R10: data_o equals mark_i at all times, including while LOS is high.
- R11: After a synchronous reset, los_o=1 and use_mclk_o=1, with all run counts, windows and history cleared.
- R12: When the selected mode differs from the mode in the previous interval, LOS goes high and all counts and history are cleared. That interval's sample is discarded.
- R13: When LOS falls, the zero-run count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interval clock, one sample per rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| mark_i | input | 1 | 1 when a pulse was received in this interval |
| lvl_ok_i | input | 1 | 1 when the received level is above the activity threshold |
| line_t1_i | input | 1 | Line type: 1 = T1 criterion, 0 = E1 criterion |
| ext_mode_i | input | 1 | 1 selects the extended E1 criterion |
| los_o | output | 1 | Loss-of-signal flag |
| use_mclk_o | output | 1 | Clock select: 1 = master clock, 0 = recovered clock |
| data_o | output | 1 | Received data passed through unchanged |

## Verification
The bench builds the monitor with shrunk thresholds. The E1 window is 8 intervals, needing 2 marks and allowing at most 3 zeros in a row, and E1 asserts after 8 zeros. T1 uses a 10-interval window needing 3 marks and asserts after 10 zeros. Extended mode asserts after 20 zeros and clears after 5 level-valid intervals. At these sizes, every set and clear path, window expiry and restart, and mode change happens within a few dozen cycles. That lets a density sweep in each mode, plus directed runs one interval either side of each set threshold, reach all of them many times over.

// File: rtl/los_pkg.sv
package los_pkg;

    typedef enum logic [1:0] {
        LM_E1  = 2'd0,
        LM_T1  = 2'd1,
        LM_EXT = 2'd2
    } los_mode_e;

    // Extended control wins over the line-type select
    function automatic los_mode_e pick_mode(input logic ext, input logic t1);
        if (ext)     return LM_EXT;
        else if (t1) return LM_T1;
        else         return LM_E1;
    endfunction

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
    parameter int RUN_MAX = 2048,
    localparam int W = $clog2(RUN_MAX + 1)
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         flush_i,
    input  logic         mark_i,
    output logic [W-1:0] run_nx_o
);
    localparam logic [W-1:0] SAT = W'(RUN_MAX);

    logic [W-1:0] run_d, run_q;

    always_comb begin
        if (mark_i)           run_nx_o = '0;
        else if (run_q == SAT) run_nx_o = SAT;
        else                   run_nx_o = run_q + W'(1);
        run_d = flush_i ? '0 : run_nx_o;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) run_q <= '0;
        else       run_q <= run_d;
    end

endmodule

// File: rtl/los_density_win.sv
module los_density_win #(
    parameter int WIN      = 32,
    parameter int MIN_MARK = 4,
    parameter int MAX_ZRUN = 15,
    localparam int CW = $clog2(WIN + 1)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic flush_i,
    input  logic mark_i,
    output logic pass_o
);
    logic [WIN-1:0] hist_d, hist_q;
    logic [WIN-1:0] win_nx;
    logic [CW-1:0]  marks;
    logic           long_gap;

    always_comb begin
        win_nx   = {hist_q[WIN-2:0], mark_i};
        marks    = '0;
        long_gap = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            marks = marks + CW'(win_nx[i]);
        end
        for (int i = 0; i + MAX_ZRUN + 1 <= WIN; i++) begin
            if (win_nx[i +: MAX_ZRUN + 1] == '0) long_gap = 1'b1;
        end
        pass_o = (marks >= CW'(MIN_MARK)) && !long_gap;
        hist_d = flush_i ? '0 : win_nx;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) hist_q <= '0;
        else       hist_q <= hist_d;
    end

endmodule

// File: rtl/los_burst_win.sv
module los_burst_win #(
    parameter int WIN      = 175,
    parameter int MIN_MARK = 22,
    localparam int PW = $clog2(WIN + 1)
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic flush_i,
    input  logic arm_i,
    input  logic mark_i,
    output logic pass_o
);
    typedef struct packed {
        logic          open;
        logic [PW-1:0] pos;
        logic [PW-1:0] cnt;
    } win_t;

    win_t          st_d, st_q;
    logic          live;
    logic          last;
    logic [PW-1:0] pos_nx;
    logic [PW-1:0] cnt_nx;

    always_comb begin
        live   = st_q.open || mark_i;
        pos_nx = st_q.open ? st_q.pos + PW'(1) : PW'(1);
        cnt_nx = st_q.open ? st_q.cnt + PW'(mark_i) : PW'(1);
        last   = live && (pos_nx == PW'(WIN));
        pass_o = arm_i && last && (cnt_nx >= PW'(MIN_MARK));
        if (flush_i || !arm_i || !live || last) begin
            st_d = '0;
        end else begin
            st_d.open = 1'b1;
            st_d.pos  = pos_nx;
            st_d.cnt  = cnt_nx;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

endmodule

// File: rtl/los_monitor.sv
module los_monitor #(
    parameter int E1_SET       = 32,
    parameter int E1_WIN       = 32,
    parameter int E1_MIN_MARKS = 4,
    parameter int E1_MAX_ZRUN  = 15,
    parameter int T1_SET       = 175,
    parameter int T1_WIN       = 175,
    parameter int T1_MIN_MARKS = 22,
    parameter int EXT_SET      = 2048,
    parameter int EXT_CLR      = 33
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic mark_i,
    input  logic lvl_ok_i,
    input  logic line_t1_i,
    input  logic ext_mode_i,
    output logic los_o,
    output logic use_mclk_o,
    output logic data_o
);
    import los_pkg::*;

    localparam int RUN_MAX_A = (E1_SET > T1_SET) ? E1_SET : T1_SET;
    localparam int RUN_MAX   = (RUN_MAX_A > EXT_SET) ? RUN_MAX_A : EXT_SET;
    localparam int RUN_W     = $clog2(RUN_MAX + 1);
    localparam int ACT_W     = $clog2(EXT_CLR + 1);
    localparam logic [ACT_W-1:0] ACT_SAT = ACT_W'(EXT_CLR);

    typedef struct packed {
        los_mode_e        mode;
        logic             los;
        logic             mclk;
        logic [ACT_W-1:0] act;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    los_mode_e        mode_now;
    logic             flush;
    logic             set_evt;
    logic             clr_evt;
    logic             run_flush;
    logic [RUN_W-1:0] run_nx;
    logic [RUN_W-1:0] thr;
    logic [ACT_W-1:0] act_nx;
    logic             e1_pass;
    logic             t1_pass;

    los_zero_run #(
        .RUN_MAX (RUN_MAX)
    ) i_zero_run (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .flush_i  (run_flush),
        .mark_i   (mark_i),
        .run_nx_o (run_nx)
    );

    los_density_win #(
        .WIN      (E1_WIN),
        .MIN_MARK (E1_MIN_MARKS),
        .MAX_ZRUN (E1_MAX_ZRUN)
    ) i_density_win (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .flush_i (flush),
        .mark_i  (mark_i),
        .pass_o  (e1_pass)
    );

    los_burst_win #(
        .WIN      (T1_WIN),
        .MIN_MARK (T1_MIN_MARKS)
    ) i_burst_win (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .flush_i (flush),
        .arm_i   (ctl_q.los),
        .mark_i  (mark_i),
        .pass_o  (t1_pass)
    );

    always_comb begin
        mode_now = pick_mode(ext_mode_i, line_t1_i);
        flush    = (mode_now != ctl_q.mode);

        unique case (ctl_q.mode)
            LM_T1:   thr = RUN_W'(T1_SET);
            LM_EXT:  thr = RUN_W'(EXT_SET);
            default: thr = RUN_W'(E1_SET);
        endcase

        if (!lvl_ok_i)              act_nx = '0;
        else if (ctl_q.act == ACT_SAT) act_nx = ACT_SAT;
        else                        act_nx = ctl_q.act + ACT_W'(1);

        clr_evt = 1'b0;
        if (ctl_q.los && !flush) begin
            unique case (ctl_q.mode)
                LM_T1:   clr_evt = t1_pass;
                LM_EXT:  clr_evt = (act_nx >= ACT_SAT);
                default: clr_evt = e1_pass && lvl_ok_i;
            endcase
        end
        set_evt   = !ctl_q.los && !flush && (run_nx >= thr);
        run_flush = flush || clr_evt;

        ctl_d.mode = mode_now;
        ctl_d.los  = flush || set_evt || (ctl_q.los && !clr_evt);
        ctl_d.mclk = ctl_q.los;
        ctl_d.act  = (flush || !ctl_q.los || clr_evt) ? '0 : act_nx;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q.mode <= pick_mode(ext_mode_i, line_t1_i);
            ctl_q.los  <= 1'b1;
            ctl_q.mclk <= 1'b1;
            ctl_q.act  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign los_o      = ctl_q.los;
    assign use_mclk_o = ctl_q.mclk;
    assign data_o     = mark_i;

endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
    input logic clk_i,
    input logic rst_i,
    input logic mark_i,
    input logic lvl_ok_i,
    input logic line_t1_i,
    input logic ext_mode_i,
    input logic los_o,
    input logic use_mclk_o
);
    import los_pkg::*;

    los_mode_e cur_mode;
    los_mode_e prev_mode_q;
    logic      seen_rst_q = 1'b0;
    logic      armed_q    = 1'b0;
    logic      chg;

    always_comb begin
        cur_mode = pick_mode(ext_mode_i, line_t1_i);
        chg      = (cur_mode != prev_mode_q);
    end

    always_ff @(posedge clk_i) begin
        prev_mode_q <= cur_mode;
        seen_rst_q  <= seen_rst_q | rst_i;
        armed_q     <= seen_rst_q;
    end

    assert_mclk_lags_los_R9: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        use_mclk_o == $past(los_o));

    assert_no_set_on_mark_R1: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        (!los_o && mark_i && !chg) |=> !los_o);

    assert_e1_needs_level_R3: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        (los_o && !lvl_ok_i && !chg && cur_mode == LM_E1) |=> los_o);

    assert_ext_needs_level_R7: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        (los_o && !lvl_ok_i && !chg && cur_mode == LM_EXT) |=> los_o);

    assert_mode_restart_R12: assert property (@(posedge clk_i) disable iff (rst_i || !armed_q)
        chg |=> los_o);

endmodule

bind los_monitor los_monitor_chk i_los_monitor_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .mark_i     (mark_i),
    .lvl_ok_i   (lvl_ok_i),
    .line_t1_i  (line_t1_i),
    .ext_mode_i (ext_mode_i),
    .los_o      (los_o),
    .use_mclk_o (use_mclk_o)
);

// File: tb/test_los_monitor.sv
module test_los_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int P_E1_SET  = 8;
    localparam int P_E1_WIN  = 8;
    localparam int P_E1_MIN  = 2;
    localparam int P_E1_ZRUN = 3;
    localparam int P_T1_SET  = 10;
    localparam int P_T1_WIN  = 10;
    localparam int P_T1_MIN  = 3;
    localparam int P_EXT_SET = 20;
    localparam int P_EXT_CLR = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mark = 1'b0;
    logic lvl = 1'b0;
    logic t1 = 1'b0;
    logic ext = 1'b0;
    logic los, use_mclk, dout;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    int        m_mode;
    bit        e_los, e_mclk;
    bit [63:0] m_hist;
    int        m_zrun, m_act, m_t1p, m_t1c;
    bit        m_t1on;
    logic [31:0] lf = 32'h1F2E_3D4C;

    always #(CLK_PERIOD / 2) clk = ~clk;

    los_monitor #(
        .E1_SET       (P_E1_SET),
        .E1_WIN       (P_E1_WIN),
        .E1_MIN_MARKS (P_E1_MIN),
        .E1_MAX_ZRUN  (P_E1_ZRUN),
        .T1_SET       (P_T1_SET),
        .T1_WIN       (P_T1_WIN),
        .T1_MIN_MARKS (P_T1_MIN),
        .EXT_SET      (P_EXT_SET),
        .EXT_CLR      (P_EXT_CLR)
    ) i_los_monitor (
        .clk_i      (clk),
        .rst_i      (rst),
        .mark_i     (mark),
        .lvl_ok_i   (lvl),
        .line_t1_i  (t1),
        .ext_mode_i (ext),
        .los_o      (los),
        .use_mclk_o (use_mclk),
        .data_o     (dout)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mode_of(input bit e, input bit t);
        return e ? 2 : (t ? 1 : 0);
    endfunction

    function automatic string los_tag(input int md);
        if (md == 0)      return "R2 R3 (E1) with R1 R8 R12 R13";
        else if (md == 1) return "R4 R5 (T1) with R1 R8 R12 R13";
        else              return "R6 R7 (EXT) with R1 R8 R12 R13";
    endfunction

    task automatic ref_restart(input int md);
        m_mode = md;
        e_los  = 1'b1;
        m_hist = '0;
        m_zrun = 0;
        m_act  = 0;
        m_t1on = 1'b0;
        m_t1p  = 0;
        m_t1c  = 0;
    endtask

    task automatic ref_step(input bit m, input bit l, input int md);
        bit nm;
        bit clr;
        int cnt, run, longest;
        nm = e_los;
        if (md != m_mode) begin
            ref_restart(md);
        end else begin
            m_hist = {m_hist[62:0], m};
            m_zrun = m ? 0 : m_zrun + 1;
            if (!e_los) begin
                if (m_zrun >= (md == 0 ? P_E1_SET : (md == 1 ? P_T1_SET : P_EXT_SET)))
                    e_los = 1'b1;
            end else begin
                clr = 1'b0;
                if (md == 0) begin
                    cnt = 0; run = 0; longest = 0;
                    for (int i = 0; i < P_E1_WIN; i++) begin
                        if (m_hist[i]) begin cnt++; run = 0; end
                        else begin run++; if (run > longest) longest = run; end
                    end
                    clr = (cnt >= P_E1_MIN) && (longest <= P_E1_ZRUN) && l;
                end else if (md == 1) begin
                    if (m_t1on) begin
                        m_t1p++;
                        m_t1c += int'(m);
                        if (m_t1p == P_T1_WIN) begin
                            clr = (m_t1c >= P_T1_MIN);
                            m_t1on = 1'b0;
                        end
                    end else if (m) begin
                        m_t1on = 1'b1;
                        m_t1p = 1;
                        m_t1c = 1;
                    end
                end else begin
                    m_act = l ? m_act + 1 : 0;
                    clr = (m_act >= P_EXT_CLR);
                end
                if (clr) begin
                    e_los  = 1'b0;
                    m_zrun = 0;
                    m_t1on = 1'b0;
                    m_act  = 0;
                end
            end
        end
        e_mclk = nm;
    endtask

    // Called right after a falling edge: drive, clock, compare
    task automatic cyc(input bit m, input bit l, input bit t, input bit e);
        mark = m; lvl = l; t1 = t; ext = e;
        #1;
        chk(dout == m, "R10 data pass-through", int'(dout), int'(m));
        @(posedge clk);
        ref_step(m, l, mode_of(e, t));
        @(negedge clk);
        chk(los == e_los, los_tag(m_mode), int'(los), int'(e_los));
        chk(use_mclk == e_mclk, "R9 clock select", int'(use_mclk), int'(e_mclk));
    endtask

    task automatic do_reset(input bit t, input bit e);
        rst = 1'b1; t1 = t; ext = e; mark = 1'b0; lvl = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_restart(mode_of(e, t));
        e_mclk = 1'b1;
        chk(los == 1'b1, "R11 reset los", int'(los), 1);
        chk(use_mclk == 1'b1, "R11 reset clock select", int'(use_mclk), 1);
    endtask

    task automatic lf_next();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    endtask

    // Recover the line, then probe one below and at the set threshold
    task automatic edge_probe(input bit t, input bit e, input int setn);
        for (int i = 0; i < 40 && e_los; i++) cyc(1'b1, 1'b1, t, e);
        chk(los == 1'b0, "R3 R5 R7 recovery on dense marks", int'(los), 0);
        for (int i = 0; i < setn - 1; i++) cyc(1'b0, 1'b1, t, e);
        chk(los == 1'b0, "R1 one zero short of threshold", int'(los), 0);
        cyc(1'b1, 1'b1, t, e);
        chk(los == 1'b0, "R1 mark restarts run", int'(los), 0);
        for (int i = 0; i < setn; i++) cyc(1'b0, 1'b1, t, e);
        chk(los == 1'b1, "R2 R4 R6 threshold reached", int'(los), 1);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        bit mt, lt;
        @(negedge clk);
        do_reset(1'b0, 1'b0);

        // directed threshold probes per mode (R8 selection incl. ext over t1)
        edge_probe(1'b0, 1'b0, P_E1_SET);
        edge_probe(1'b1, 1'b0, P_T1_SET);
        edge_probe(1'b1, 1'b1, P_EXT_SET);
        edge_probe(1'b0, 1'b1, P_EXT_SET);

        // mode change restarts detection (R12)
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0);
        chk(los == 1'b1, "R12 restart on mode change", int'(los), 1);

        // density sweep in each mode
        for (int md = 0; md < 3; md++) begin
            do_reset(md == 1, md == 2);
            for (int dens = 0; dens <= 16; dens += 2) begin
                for (int k = 0; k < 300; k++) begin
                    lf_next();
                    mt = (lf[3:0] < dens);
                    lt = (dens > 0) ? (lf[11:8] != 4'd0) : (lf[9:8] == 2'd0);
                    cyc(mt, lt, md == 1, md == 2);
                end
            end
        end

        // random mode switching mixed with traffic
        for (int k = 0; k < 1500; k++) begin
            lf_next();
            if (lf[20:15] == 6'd0) begin
                t1 = lf[21];
                ext = lf[22];
            end
            cyc(lf[2:0] != 3'd0, lf[7:5] != 3'd0, t1, ext);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule